// File: doc/BRIEF.md
# DMA Channel Control and Status Registers

This block is the software-facing register file of a multi-channel, descriptor-driven DMA engine. A single 32-bit register port is split into per-channel windows of 128 bytes. Each window holds a write-only control word, a status word, a command pointer and three condition-select words. The control word carries a per-bit write mask in its upper half, and its value in the lower half is merged into the status word. The run, pause and wake requests then decide the ACTIVE and DEAD flags.

A descriptor sequencer sits beside the block. It reads the status word, the command pointer and the select words straight from output vectors. It updates the ACTIVE, DEAD, FLUSH, WAKE and branch-taken flags through per-channel set and clear strobes. The block sends three one-cycle pulses per channel: a schedule pulse when a control write leaves the channel active, a flush request to the attached device when it leaves FLUSH set, and a descriptor fetch request when a command pointer write is accepted.

Top module: `dma_chan_csr`

## Requirements
- R1: After reset, every status word, command pointer and select word of every channel is zero, and all pulse outputs and the read-valid output are low.
- R2: The channel number is taken from address bits [ADDR_W-1:7] and the register index from bits [5:2]. Bit 6 and bits [1:0] are ignored. The indices are 0 control, 1 status, 3 command pointer, 4 interrupt select, 5 branch select and 6 wait select.
- R3: A control write uses bits [31:16] as the mask and bits [15:0] as the value. Only RUN (bit 15), PAUSE (14), FLUSH (13), WAKE (12) and the device field (7:0) take the value. A masked position of DEAD (11), ACTIVE (10), bit 9 or branch-taken (8) is cleared. Unmasked bits keep their old state.
- R4: After the merge, the following rules apply in this order. WAKE set forces ACTIVE. RUN set forces ACTIVE and clears DEAD. PAUSE set clears ACTIVE. RUN going from 1 to 0 in the write clears both ACTIVE and DEAD.
- R5: A command pointer write is ignored while RUN or ACTIVE is set. An accepted write stores the value with bits [3:0] forced to zero and raises that channel's fetch request for one cycle, one cycle after the write.
- R6: A read returns data one cycle after the request, with read-valid high for that cycle. The control word and every index other than 1, 3, 4, 5 and 6 read as zero. Status reads as the 16-bit word zero-extended. The pointer and the select words read back their stored values.
- R7: One cycle after a control write, that channel's schedule pulse is high for one cycle if the resulting ACTIVE is set. Its flush request is high for one cycle if the resulting FLUSH is set.
- R8: A write whose byte enables are not all ones changes nothing. A read returns the full word whatever the byte enables are.
- R9: The sequencer strobe vectors hold five bits per channel, in the order ACTIVE (0), DEAD (1), FLUSH (2), WAKE (3), branch-taken (4). A set strobe forces the flag to 1. Otherwise a clear strobe forces it to 0, so set wins over clear. A strobe overrides a same-cycle control write only for the flag it touches.
- R10: Writes to the status index and to indices that read as zero have no effect on any stored state.
- R11: A write to one channel leaves the state of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| seq_set_flags | input | NUM_CH*5 | Sequencer flag set strobes |
| seq_clr_flags | input | NUM_CH*5 | Sequencer flag clear strobes |
| status_o | output | NUM_CH*16 | Status words |
| cmd_ptr_o | output | NUM_CH*32 | Command pointers |
| intr_sel_o | output | NUM_CH*32 | Interrupt select words |
| branch_sel_o | output | NUM_CH*32 | Branch select words |
| wait_sel_o | output | NUM_CH*32 | Wait select words |
| sched_pulse_o | output | NUM_CH | Schedule pulses |
| flush_req_o | output | NUM_CH | Flush requests |
| fetch_req_o | output | NUM_CH | Descriptor fetch requests |

## Verification
A write, and any sequencer strobe issued with it, is sampled on one rising edge. The updated status, pointer and select outputs, together with the schedule, flush and fetch pulses, are all due right after that edge and last one cycle for the pulses. Read data and read-valid are due one edge after the read request. The bench drives each access at a falling edge and checks at the next falling edge. A pulse is therefore seen in the one cycle it exists, and its absence is checked in that same cycle.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;

  localparam int STAT_W    = 16;
  localparam int NUM_FLAGS = 5;
  localparam int CH_SHIFT  = 7;

  // status bit positions
  localparam int B_RUN    = 15;
  localparam int B_PAUSE  = 14;
  localparam int B_FLUSH  = 13;
  localparam int B_WAKE   = 12;
  localparam int B_DEAD   = 11;
  localparam int B_ACTIVE = 10;
  localparam int B_BT     = 8;

  localparam logic [STAT_W-1:0] SW_WRITABLE = 16'hF0FF;

  // register indices
  localparam logic [3:0] IDX_CTRL = 4'd0;
  localparam logic [3:0] IDX_STAT = 4'd1;
  localparam logic [3:0] IDX_PTR  = 4'd3;
  localparam logic [3:0] IDX_ISEL = 4'd4;
  localparam logic [3:0] IDX_BSEL = 4'd5;
  localparam logic [3:0] IDX_WSEL = 4'd6;

  // sequencer flag order
  localparam int FL_ACTIVE = 0;
  localparam int FL_DEAD   = 1;
  localparam int FL_FLUSH  = 2;
  localparam int FL_WAKE   = 3;
  localparam int FL_BT     = 4;

  function automatic int flag_pos(input int k);
    case (k)
      FL_ACTIVE: return B_ACTIVE;
      FL_DEAD:   return B_DEAD;
      FL_FLUSH:  return B_FLUSH;
      FL_WAKE:   return B_WAKE;
      default:   return B_BT;
    endcase
  endfunction

  // masked merge of a control write followed by the interlock rules
  function automatic logic [STAT_W-1:0] ctrl_merge(input logic [STAT_W-1:0] old_s,
                                                    input logic [31:0] w);
    logic [STAT_W-1:0] msk, val, s;
    msk = w[31:16];
    val = w[15:0] & SW_WRITABLE;
    s   = (val & msk) | (old_s & ~msk);
    if (s[B_WAKE]) s[B_ACTIVE] = 1'b1;
    if (s[B_RUN]) begin
      s[B_ACTIVE] = 1'b1;
      s[B_DEAD]   = 1'b0;
    end
    if (s[B_PAUSE]) s[B_ACTIVE] = 1'b0;
    if (old_s[B_RUN] && !s[B_RUN]) begin
      s[B_ACTIVE] = 1'b0;
      s[B_DEAD]   = 1'b0;
    end
    return s;
  endfunction

  function automatic logic [31:0] align_ptr(input logic [31:0] w);
    return {w[31:4], 4'h0};
  endfunction

  function automatic logic [31:0] read_value(input logic [3:0] idx,
                                             input logic [STAT_W-1:0] st,
                                             input logic [31:0] ptr,
                                             input logic [31:0] isel,
                                             input logic [31:0] bsel,
                                             input logic [31:0] wsel);
    case (idx)
      IDX_STAT: return {{(32-STAT_W){1'b0}}, st};
      IDX_PTR:  return ptr;
      IDX_ISEL: return isel;
      IDX_BSEL: return bsel;
      IDX_WSEL: return wsel;
      default:  return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
  import dmacsr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int ADDR_W = CH_SHIFT + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  output logic [NUM_CH-1:0] ctrl_wr,
  output logic [NUM_CH-1:0] ptr_wr,
  output logic [NUM_CH-1:0] isel_wr,
  output logic [NUM_CH-1:0] bsel_wr,
  output logic [NUM_CH-1:0] wsel_wr,
  output logic              rd_en,
  output logic [CH_W-1:0]   rd_ch,
  output logic [3:0]        rd_idx
);

  logic [CH_W-1:0] ch_field;
  logic [3:0]      idx_field;
  logic            full_word;
  logic            wr_en;
  logic            unused_addr;

  assign ch_field    = bus_addr[ADDR_W-1:CH_SHIFT];
  assign idx_field   = bus_addr[5:2];
  assign full_word   = (bus_be == 4'hF);
  assign wr_en       = bus_req && bus_we && full_word;
  assign rd_en       = bus_req && !bus_we;
  assign rd_ch       = ch_field;
  assign rd_idx      = idx_field;
  assign unused_addr = ^{bus_addr[6], bus_addr[1:0]};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit        = wr_en && (ch_field == CH_W'(c));
    assign ctrl_wr[c] = hit && (idx_field == IDX_CTRL);
    assign ptr_wr[c]  = hit && (idx_field == IDX_PTR);
    assign isel_wr[c] = hit && (idx_field == IDX_ISEL);
    assign bsel_wr[c] = hit && (idx_field == IDX_BSEL);
    assign wsel_wr[c] = hit && (idx_field == IDX_WSEL);
  end

  AST_ONE_CTRL_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctrl_wr | ptr_wr | isel_wr | bsel_wr | wsel_wr)); // R11
  AST_PARTIAL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_be != 4'hF) |-> ((ctrl_wr | ptr_wr | isel_wr | bsel_wr | wsel_wr) == '0)); // R8

endmodule

// File: rtl/dmacsr_chan.sv
module dmacsr_chan
  import dmacsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_wr,
  input  logic                 ptr_wr,
  input  logic                 isel_wr,
  input  logic                 bsel_wr,
  input  logic                 wsel_wr,
  input  logic [31:0]          wdata,
  input  logic [NUM_FLAGS-1:0] seq_set,
  input  logic [NUM_FLAGS-1:0] seq_clr,
  output logic [STAT_W-1:0]    status_q,
  output logic [31:0]          cmd_ptr_q,
  output logic [31:0]          isel_q,
  output logic [31:0]          bsel_q,
  output logic [31:0]          wsel_q,
  output logic                 sched_pulse,
  output logic                 flush_req,
  output logic                 fetch_req
);

  logic [STAT_W-1:0] sw_status;
  logic [STAT_W-1:0] status_d;
  logic              ptr_locked;
  logic              ptr_accept;
  logic              no_seq;

  assign ptr_locked = status_q[B_RUN] | status_q[B_ACTIVE];
  assign ptr_accept = ptr_wr & ~ptr_locked;
  assign no_seq     = (seq_set == '0) && (seq_clr == '0);

  always_comb begin
    sw_status = ctrl_wr ? ctrl_merge(status_q, wdata) : status_q;
    status_d  = sw_status;
    for (int k = 0; k < NUM_FLAGS; k++) begin
      if (seq_set[k])      status_d[flag_pos(k)] = 1'b1;
      else if (seq_clr[k]) status_d[flag_pos(k)] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q    <= '0;
      cmd_ptr_q   <= '0;
      isel_q      <= '0;
      bsel_q      <= '0;
      wsel_q      <= '0;
      sched_pulse <= 1'b0;
      flush_req   <= 1'b0;
      fetch_req   <= 1'b0;
    end else begin
      status_q    <= status_d;
      sched_pulse <= ctrl_wr && status_d[B_ACTIVE];
      flush_req   <= ctrl_wr && status_d[B_FLUSH];
      fetch_req   <= ptr_accept;
      if (ptr_accept) cmd_ptr_q <= align_ptr(wdata);
      if (isel_wr)    isel_q    <= wdata;
      if (bsel_wr)    bsel_q    <= wdata;
      if (wsel_wr)    wsel_q    <= wdata;
    end
  end

  AST_PTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && ptr_locked) |=> $stable(cmd_ptr_q)); // R5
  AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (cmd_ptr_q[3:0] == 4'h0)); // R5
  AST_RUN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && no_seq) |=> (!status_q[B_RUN] || status_q[B_PAUSE] || status_q[B_ACTIVE])); // R4
  AST_RUN_NOT_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && no_seq) |=> !(status_q[B_RUN] && status_q[B_DEAD])); // R4
  AST_RUN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && no_seq && status_q[B_RUN]) |=>
      (status_q[B_RUN] || !(status_q[B_ACTIVE] || status_q[B_DEAD]))); // R4
  AST_SCHED_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    sched_pulse |-> status_q[B_ACTIVE]); // R7
  AST_SCHED_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_pulse || flush_req) |-> $past(ctrl_wr)); // R7
  AST_FLUSH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> status_q[B_FLUSH]); // R7
  AST_SEQ_SET_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_set[FL_DEAD] |=> status_q[B_DEAD]); // R9
  AST_SEQ_CLR_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_clr[FL_ACTIVE] && !seq_set[FL_ACTIVE]) |=> !status_q[B_ACTIVE]); // R9

endmodule

// File: rtl/dmacsr_rdmux.sv
module dmacsr_rdmux
  import dmacsr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic [CH_W-1:0]          rd_ch,
  input  logic [3:0]               rd_idx,
  input  logic [NUM_CH*STAT_W-1:0] status_all,
  input  logic [NUM_CH*32-1:0]     ptr_all,
  input  logic [NUM_CH*32-1:0]     isel_all,
  input  logic [NUM_CH*32-1:0]     bsel_all,
  input  logic [NUM_CH*32-1:0]     wsel_all,
  output logic [31:0]              rdata,
  output logic                     rvalid
);

  logic [31:0] rdata_d;

  always_comb begin
    rdata_d = read_value(rd_idx,
                         status_all[rd_ch*STAT_W +: STAT_W],
                         ptr_all[rd_ch*32 +: 32],
                         isel_all[rd_ch*32 +: 32],
                         bsel_all[rd_ch*32 +: 32],
                         wsel_all[rd_ch*32 +: 32]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rdata_d;
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid); // R6
  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_en)); // R6

endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dmacsr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int ADDR_W = CH_SHIFT + CH_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_req,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [3:0]                  bus_be,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        bus_rvalid,
  input  logic [NUM_CH*NUM_FLAGS-1:0] seq_set_flags,
  input  logic [NUM_CH*NUM_FLAGS-1:0] seq_clr_flags,
  output logic [NUM_CH*STAT_W-1:0]    status_o,
  output logic [NUM_CH*32-1:0]        cmd_ptr_o,
  output logic [NUM_CH*32-1:0]        intr_sel_o,
  output logic [NUM_CH*32-1:0]        branch_sel_o,
  output logic [NUM_CH*32-1:0]        wait_sel_o,
  output logic [NUM_CH-1:0]           sched_pulse_o,
  output logic [NUM_CH-1:0]           flush_req_o,
  output logic [NUM_CH-1:0]           fetch_req_o
);

  logic [NUM_CH-1:0] ctrl_wr, ptr_wr, isel_wr, bsel_wr, wsel_wr;
  logic              rd_en;
  logic [CH_W-1:0]   rd_ch;
  logic [3:0]        rd_idx;

  dmacsr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .ctrl_wr  (ctrl_wr),
    .ptr_wr   (ptr_wr),
    .isel_wr  (isel_wr),
    .bsel_wr  (bsel_wr),
    .wsel_wr  (wsel_wr),
    .rd_en    (rd_en),
    .rd_ch    (rd_ch),
    .rd_idx   (rd_idx)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dmacsr_chan u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_wr     (ctrl_wr[c]),
      .ptr_wr      (ptr_wr[c]),
      .isel_wr     (isel_wr[c]),
      .bsel_wr     (bsel_wr[c]),
      .wsel_wr     (wsel_wr[c]),
      .wdata       (bus_wdata),
      .seq_set     (seq_set_flags[c*NUM_FLAGS +: NUM_FLAGS]),
      .seq_clr     (seq_clr_flags[c*NUM_FLAGS +: NUM_FLAGS]),
      .status_q    (status_o[c*STAT_W +: STAT_W]),
      .cmd_ptr_q   (cmd_ptr_o[c*32 +: 32]),
      .isel_q      (intr_sel_o[c*32 +: 32]),
      .bsel_q      (branch_sel_o[c*32 +: 32]),
      .wsel_q      (wait_sel_o[c*32 +: 32]),
      .sched_pulse (sched_pulse_o[c]),
      .flush_req   (flush_req_o[c]),
      .fetch_req   (fetch_req_o[c])
    );
  end

  dmacsr_rdmux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rdmux (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .rd_ch      (rd_ch),
    .rd_idx     (rd_idx),
    .status_all (status_o),
    .ptr_all    (cmd_ptr_o),
    .isel_all   (intr_sel_o),
    .bsel_all   (branch_sel_o),
    .wsel_all   (wait_sel_o),
    .rdata      (bus_rdata),
    .rvalid     (bus_rvalid)
  );

  AST_PARTIAL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_be != 4'hF) |=> (fetch_req_o == '0)); // R8
  AST_READ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> (sched_pulse_o == '0 && flush_req_o == '0)); // R6

endmodule

// File: tb/dma_chan_csr_bench.sv
module dma_chan_csr_bench;

  localparam int NCH = 4;
  localparam int AW  = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [3:0]       bus_be = 4'hF;
  logic [31:0]      bus_wdata = '0;
  logic [31:0]      bus_rdata;
  logic             bus_rvalid;
  logic [NCH*5-1:0] seq_set = '0, seq_clr = '0;
  logic [NCH*16-1:0] status_o;
  logic [NCH*32-1:0] cmd_ptr_o, intr_sel_o, branch_sel_o, wait_sel_o;
  logic [NCH-1:0]    sched_pulse_o, flush_req_o, fetch_req_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dma_chan_csr u_dma_chan_csr (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .seq_set_flags(seq_set), .seq_clr_flags(seq_clr),
    .status_o(status_o), .cmd_ptr_o(cmd_ptr_o), .intr_sel_o(intr_sel_o),
    .branch_sel_o(branch_sel_o), .wait_sel_o(wait_sel_o),
    .sched_pulse_o(sched_pulse_o), .flush_req_o(flush_req_o),
    .fetch_req_o(fetch_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int ch, input int idx, input bit a6);
    return AW'((ch << 7) | (int'(a6) << 6) | (idx << 2));
  endfunction

  // expected status after a control write, written as explicit bit rules
  function automatic logic [15:0] model_ctrl(input logic [15:0] prev, input logic [31:0] w);
    logic [15:0] r;
    for (int b = 0; b < 16; b++) begin
      if (!w[16+b])                   r[b] = prev[b];
      else if (b >= 12 || b <= 7)     r[b] = w[b];
      else                            r[b] = 1'b0;
    end
    if (r[12] || r[15]) r[10] = 1'b1;
    if (r[15]) r[11] = 1'b0;
    if (r[14]) r[10] = 1'b0;
    if (prev[15] && !r[15]) begin r[10] = 1'b0; r[11] = 1'b0; end
    return r;
  endfunction

  task automatic bus_write(input int ch, input int idx, input logic [31:0] d,
                           input logic [3:0] be = 4'hF, input bit a6 = 1'b0);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(ch, idx, a6);
    bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; bus_be = 4'hF;
    seq_set = '0; seq_clr = '0;
  endtask

  task automatic bus_read(input int ch, input int idx, output logic [31:0] d,
                          input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = mk_addr(ch, idx, 1'b0); bus_be = be;
    @(negedge clk);
    bus_req = 1'b0; bus_be = 4'hF;
    check("R6 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  function automatic logic [15:0] st(input int ch);
    return status_o[ch*16 +: 16];
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < NCH; c++) begin
      check("R1 status", {16'h0, st(c)}, 32'h0);
      check("R1 cmd_ptr", cmd_ptr_o[c*32 +: 32], 32'h0);
    end
    check("R1 pulses", {20'h0, sched_pulse_o, flush_req_o, fetch_req_o}, 32'h0);
    check("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
    bus_read(3, 4, d); check("R1 isel read", d, 32'h0);
  endtask

  task automatic t_ctrl_merge();
    logic [31:0] d;
    bus_write(1, 0, 32'h00FF_00A5);
    check("R3 dev field", {16'h0, st(1)}, {16'h0, model_ctrl(16'h0, 32'h00FF_00A5)});
    check("R7 no sched/flush", {28'h0, sched_pulse_o | flush_req_o}, 32'h0);
    check("R11 other ch", {16'h0, st(0) | st(2) | st(3)}, 32'h0);
    bus_read(1, 1, d); check("R6 status read", d, 32'h0000_00A5);
    bus_read(1, 0, d); check("R6 ctrl reads 0", d, 32'h0);
    bus_write(1, 0, 32'h000F_0000);
    check("R3 unmasked kept", {16'h0, st(1)}, 32'h0000_00A0);
  endtask

  task automatic t_run_pause();
    logic [15:0] e;
    e = 16'h00A0;
    bus_write(1, 0, 32'h8000_8000); e = model_ctrl(e, 32'h8000_8000);
    check("R4 run->active", {16'h0, st(1)}, {16'h0, e});
    check("R4 run value", {16'h0, st(1)}, 32'h0000_84A0);
    check("R7 sched ch1", {28'h0, sched_pulse_o}, 32'h2);
    bus_write(1, 3, 32'h0000_1238);
    check("R5 locked ptr", cmd_ptr_o[32 +: 32], 32'h0);
    check("R5 no fetch", {28'h0, fetch_req_o}, 32'h0);
    @(negedge clk); seq_set[1*5 + 1] = 1'b1;  // R9 DEAD set by sequencer
    @(negedge clk); seq_set = '0; e[11] = 1'b1;
    check("R9 seq dead set", {16'h0, st(1)}, {16'h0, e});
    bus_write(1, 0, 32'h4000_4000); e = model_ctrl(e, 32'h4000_4000);
    check("R4 pause clears active", {16'h0, st(1)}, {16'h0, e});
    check("R7 no sched when paused", {28'h0, sched_pulse_o}, 32'h0);
    bus_write(1, 0, 32'h8000_0000); e = model_ctrl(e, 32'h8000_0000);
    check("R4 run fall", {16'h0, st(1)}, {16'h0, e});
    check("R4 run fall value", {16'h0, st(1)}, 32'h0000_40A0);
  endtask

  task automatic t_wake_ptr();
    logic [31:0] d;
    bus_write(2, 0, 32'h1000_1000);
    check("R4 wake->active", {16'h0, st(2)}, 32'h0000_1400);
    check("R7 sched ch2", {28'h0, sched_pulse_o}, 32'h4);
    @(negedge clk); seq_clr[2*5 + 3] = 1'b1;
    @(negedge clk); seq_clr = '0;
    check("R9 seq clr wake", {16'h0, st(2)}, 32'h0000_0400);
    bus_write(2, 3, 32'h1234_567F);
    check("R5 locked by active", cmd_ptr_o[64 +: 32], 32'h0);
    @(negedge clk); seq_clr[2*5 + 0] = 1'b1;
    @(negedge clk); seq_clr = '0;
    bus_write(2, 3, 32'h1234_567F);
    check("R5 aligned ptr", cmd_ptr_o[64 +: 32], 32'h1234_5670);
    check("R5 fetch ch2", {28'h0, fetch_req_o}, 32'h4);
    @(negedge clk);
    check("R5 fetch one cycle", {28'h0, fetch_req_o}, 32'h0);
    bus_read(2, 3, d); check("R6 ptr read", d, 32'h1234_5670);
  endtask

  task automatic t_flush_clear();
    bus_write(3, 0, 32'h2000_2000);
    check("R7 flush ch3", {28'h0, flush_req_o}, 32'h8);
    check("R7 no sched ch3", {28'h0, sched_pulse_o}, 32'h0);
    @(negedge clk); seq_set[3*5 + 0] = 1'b1; seq_set[3*5 + 4] = 1'b1;
    @(negedge clk); seq_set = '0;
    check("R9 seq set active/bt", {16'h0, st(3)}, 32'h0000_2500);
    bus_write(3, 0, 32'h0500_0500);
    check("R3 masked ro bits cleared", {16'h0, st(3)}, 32'h0000_2000);
    check("R7 flush again", {28'h0, flush_req_o}, 32'h8);
  endtask

  task automatic t_seq_priority();
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = mk_addr(0, 0, 1'b0); bus_wdata = 32'h8000_8000;
    seq_clr[0] = 1'b1;               // ACTIVE clear wins over control write
    seq_set[1] = 1'b1; seq_clr[1] = 1'b1; // DEAD: set wins over clear
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0; seq_set = '0; seq_clr = '0;
    check("R9 seq override", {16'h0, st(0)}, 32'h0000_8800);
    check("R9 no sched when cleared", {28'h0, sched_pulse_o}, 32'h0);
    bus_write(0, 0, 32'h8000_0000);
    check("R4 stop ch0", {16'h0, st(0)}, 32'h0);
  endtask

  task automatic t_selects();
    logic [31:0] d;
    bus_write(2, 4, 32'h000F_0003);
    bus_write(2, 5, 32'h00A0_0055);
    bus_write(2, 6, 32'hDEAD_BEEF, 4'hF, 1'b1);
    bus_read(2, 4, d); check("R6 isel", d, 32'h000F_0003);
    bus_read(2, 5, d); check("R6 bsel", d, 32'h00A0_0055);
    bus_read(2, 6, d); check("R2 wsel via bit6 alias", d, 32'hDEAD_BEEF);
    check("R2 wsel port", wait_sel_o[64 +: 32], 32'hDEAD_BEEF);
    bus_write(2, 7, 32'hFFFF_FFFF); bus_read(2, 7, d); check("R10 idx7 zero", d, 32'h0);
    bus_write(2, 2, 32'hFFFF_FFFF); bus_read(2, 2, d); check("R10 idx2 zero", d, 32'h0);
    bus_write(2, 13, 32'h1111_1111); bus_read(2, 13, d); check("R10 idx13 zero", d, 32'h0);
    bus_write(2, 1, 32'h0000_FFFF);
    check("R10 status write ignored", {16'h0, st(2)}, 32'h0);
  endtask

  task automatic t_byte_en();
    logic [31:0] d;
    bus_write(2, 4, 32'h1234_5678, 4'h3);
    bus_read(2, 4, d, 4'h0);
    check("R8 partial write ignored / full read", d, 32'h000F_0003);
    bus_write(1, 0, 32'h8000_8000, 4'h7);
    check("R8 partial ctrl ignored", {16'h0, st(1)}, 32'h0000_40A0);
    check("R8 no sched", {28'h0, sched_pulse_o}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_merge();
    t_run_pause();
    t_wake_ptr();
    t_flush_clear();
    t_seq_priority();
    t_selects();
    t_byte_en();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule